// File: doc/BRIEF.md
# Copy-Job Register Front End with Transfer Tickets

This block is the software-facing side of a copy engine. A processor writes the job into a set of 64-bit registers: where to read, where to write, how many bytes, three option flags, a stride for each side and a repeat count for two-dimensional copies. It then reads one register. That read starts the job and returns a ticket number. The engine behind the block is reduced here to a job port with a valid/ready handshake and a one-cycle completion pulse.

The processor waits by polling a completion register until it shows its own ticket. A ticket of 0 means the job was refused. Tickets are issued in order and jobs finish in order. The completion register therefore steps through the tickets one at a time, once per completion pulse. A status register shows whether any job is still outstanding.

Top module: `dma_job_regs`

## Requirements
- R1: Word offsets 0x00 (source), 0x08 (destination), 0x10 (byte count), 0x38 (source stride), 0x40 (destination stride) and 0x48 (repeat count) are writable. Each holds 64 bits, reads back what was written and drives the matching job output.
- R2: The option register at 0x18 keeps only bit 0 (decouple), bit 1 (deburst) and bit 2 (serialize). Higher bits read as 0. The three bits drive `job_decouple_o`, `job_deburst_o` and `job_serialize_o`.
- R3: A read of 0x28 raises `job_valid_o` in that same cycle, with the current register contents on the job outputs. If `job_ready_i` is also high, the job is accepted and the read returns `job_id_o`, zero-extended.
- R4: The first ticket after reset is 1. Each accepted job advances the ticket by one. After 2^IdWidth-1 the ticket wraps to 1, so a valid ticket is never 0.
- R5: A read of 0x28 returns 0 and no job is accepted in any of these cases: the byte count is 0, `job_ready_i` is low, or 2^IdWidth-1 jobs are already outstanding. In the first and last case `job_valid_o` also stays low.
- R6: The completion register at 0x30 reads 0 after reset. Each `done_i` pulse moves it on to the oldest outstanding ticket. A pulse that arrives with nothing outstanding is ignored.
- R7: Bit 0 of the status register at 0x20 is 1 while at least one accepted job has not completed. All other status bits read as 0.
- R8: Writes to 0x20, 0x28 and 0x30 change no state. Reads of offsets above 0x48 return 0.
- R9: Every request is answered one cycle later, with `rsp_valid_o` high. The response carries the read data for a read and 0 for a write.
- R10: `job_two_d_o` is 1 exactly when the repeat count is nonzero. A count of 0 marks a plain one-dimensional copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AddrWidth | Byte address; bits [2:0] ignored |
| wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_rdata_o | output | 64 | Response data |
| job_valid_o | output | 1 | Job offered on the launch read |
| job_ready_i | input | 1 | Engine takes the job |
| job_id_o | output | IdWidth | Ticket of the offered job |
| job_src_o | output | 64 | Source address |
| job_dst_o | output | 64 | Destination address |
| job_len_o | output | 64 | Byte count |
| job_src_stride_o | output | 64 | Source stride |
| job_dst_stride_o | output | 64 | Destination stride |
| job_reps_o | output | 64 | Repeat count |
| job_decouple_o | output | 1 | Option flag bit 0 |
| job_deburst_o | output | 1 | Option flag bit 1 |
| job_serialize_o | output | 1 | Option flag bit 2 |
| job_two_d_o | output | 1 | Repeat count is nonzero |
| done_i | input | 1 | One-cycle completion pulse from the engine |

## Verification
The assertions assume that the engine holds `job_ready_i` steady within a cycle. They also assume that `done_i` pulses at most once per cycle, and only for jobs that were actually accepted. The bench drives every input at the falling clock edge and raises `done_i` only after a launch has returned a nonzero ticket. The bench also issues a single request at a time, with an idle cycle in between, so every response can be matched to the request that caused it.

// File: rtl/dma_job_pkg.sv
package dma_job_pkg;

  localparam int REG_W    = 64;
  localparam int NUM_REGS = 10;
  localparam int CFG_W    = 3;

  // word indices (byte offset / 8)
  localparam int IX_SRC    = 0;
  localparam int IX_DST    = 1;
  localparam int IX_LEN    = 2;
  localparam int IX_CFG    = 3;
  localparam int IX_STAT   = 4;
  localparam int IX_LAUNCH = 5;
  localparam int IX_DONE   = 6;
  localparam int IX_SSTR   = 7;
  localparam int IX_DSTR   = 8;
  localparam int IX_REPS   = 9;

  // one bit per word: 1 = software-writable storage
  localparam logic [NUM_REGS-1:0] WRITABLE = 10'b11_1000_1111;

  typedef struct packed {
    logic [REG_W-1:0] src;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] len;
    logic [CFG_W-1:0] cfg;
    logic [REG_W-1:0] sstr;
    logic [REG_W-1:0] dstr;
    logic [REG_W-1:0] reps;
  } job_desc_t;

endpackage

// File: rtl/dma_job_cfg.sv
module dma_job_cfg
  import dma_job_pkg::*;
#(
  parameter int IdxW = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IdxW-1:0]     wr_idx_i,
  input  logic [REG_W-1:0]    wr_data_i,
  input  logic [IdxW-1:0]     rd_idx_i,
  output logic [REG_W-1:0]    rd_val_o,
  output job_desc_t           desc_o
);

  localparam logic [REG_W-1:0] CFG_MASK = {{(REG_W-CFG_W){1'b0}}, {CFG_W{1'b1}}};

  logic [REG_W-1:0] word_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    if (WRITABLE[i]) begin : g_store
      logic [REG_W-1:0] val_d, val_q;
      logic             val_en;
      assign val_en = wr_en_i && (int'(wr_idx_i) == i);
      always_comb begin
        val_d = val_q;
        if (val_en) val_d = (i == IX_CFG) ? (wr_data_i & CFG_MASK) : wr_data_i;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     val_q <= '0;
        else if (val_en) val_q <= val_d;
      end
      assign word_q[i] = val_q;
    end else begin : g_none
      assign word_q[i] = '0;
    end
  end

  always_comb begin
    rd_val_o = '0;
    if (int'(rd_idx_i) < NUM_REGS) rd_val_o = word_q[rd_idx_i];
  end

  assign desc_o.src  = word_q[IX_SRC];
  assign desc_o.dst  = word_q[IX_DST];
  assign desc_o.len  = word_q[IX_LEN];
  assign desc_o.cfg  = word_q[IX_CFG][CFG_W-1:0];
  assign desc_o.sstr = word_q[IX_SSTR];
  assign desc_o.dstr = word_q[IX_DSTR];
  assign desc_o.reps = word_q[IX_REPS];

endmodule

// File: rtl/dma_job_ids.sv
module dma_job_ids #(
  parameter int IdWidth = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  logic               done_i,
  output logic [IdWidth-1:0] next_id_o,
  output logic [IdWidth-1:0] done_id_o,
  output logic               full_o,
  output logic               busy_o
);

  localparam logic [IdWidth-1:0] MAX_ID = {IdWidth{1'b1}};
  localparam logic [IdWidth-1:0] ONE    = {{(IdWidth-1){1'b0}}, 1'b1};

  function automatic logic [IdWidth-1:0] bump(input logic [IdWidth-1:0] v);
    return (v == MAX_ID) ? ONE : v + ONE;
  endfunction

  logic [IdWidth-1:0] next_d, next_q, done_d, done_q, cnt_d, cnt_q;
  logic               retire, cnt_en;

  assign retire = done_i && (cnt_q != '0);
  assign cnt_en = accept_i || retire;

  always_comb begin
    next_d = accept_i ? bump(next_q) : next_q;
    done_d = retire   ? bump(done_q) : done_q;
    cnt_d  = cnt_q;
    if (accept_i && !retire)      cnt_d = cnt_q + ONE;
    else if (!accept_i && retire) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       next_q <= ONE;
    else if (accept_i) next_q <= next_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     done_q <= '0;
    else if (retire) done_q <= done_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign next_id_o = next_q;
  assign done_id_o = done_q;
  assign full_o    = (cnt_q == MAX_ID);
  assign busy_o    = (cnt_q != '0);

endmodule

// File: rtl/dma_job_regs.sv
module dma_job_regs
  import dma_job_pkg::*;
#(
  parameter int AddrWidth = 7,
  parameter int IdWidth   = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [AddrWidth-1:0] addr_i,
  input  logic [63:0]          wdata_i,
  output logic                 rsp_valid_o,
  output logic [63:0]          rsp_rdata_o,
  output logic                 job_valid_o,
  input  logic                 job_ready_i,
  output logic [IdWidth-1:0]   job_id_o,
  output logic [63:0]          job_src_o,
  output logic [63:0]          job_dst_o,
  output logic [63:0]          job_len_o,
  output logic [63:0]          job_src_stride_o,
  output logic [63:0]          job_dst_stride_o,
  output logic [63:0]          job_reps_o,
  output logic                 job_decouple_o,
  output logic                 job_deburst_o,
  output logic                 job_serialize_o,
  output logic                 job_two_d_o,
  input  logic                 done_i
);

  localparam int IdxW = AddrWidth - 3;

  logic [IdxW-1:0]    idx;
  logic               rd_req, wr_req, launch_rd, accept;
  logic [REG_W-1:0]   store_val, rdata_d, rdata_q;
  logic               rvalid_q;
  logic [IdWidth-1:0] next_id, done_id;
  logic               full, busy;
  job_desc_t          desc;

  assign idx    = addr_i[AddrWidth-1:3];
  assign rd_req = req_i && !we_i;
  assign wr_req = req_i && we_i;

  dma_job_cfg #(.IdxW(IdxW)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_req),
    .wr_idx_i  (idx),
    .wr_data_i (wdata_i),
    .rd_idx_i  (idx),
    .rd_val_o  (store_val),
    .desc_o    (desc)
  );

  assign launch_rd   = rd_req && (int'(idx) == IX_LAUNCH);
  assign job_valid_o = launch_rd && (desc.len != '0) && !full;
  assign accept      = job_valid_o && job_ready_i;

  dma_job_ids #(.IdWidth(IdWidth)) u_ids (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .done_i    (done_i),
    .next_id_o (next_id),
    .done_id_o (done_id),
    .full_o    (full),
    .busy_o    (busy)
  );

  always_comb begin
    case (int'(idx))
      IX_STAT:   rdata_d = {{(REG_W-1){1'b0}}, busy};
      IX_LAUNCH: rdata_d = accept ? {{(REG_W-IdWidth){1'b0}}, next_id} : '0;
      IX_DONE:   rdata_d = {{(REG_W-IdWidth){1'b0}}, done_id};
      default:   rdata_d = store_val;
    endcase
    if (we_i) rdata_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_q <= 1'b0;
    else         rvalid_q <= req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (req_i) rdata_q <= rdata_d;
  end

  assign rsp_valid_o      = rvalid_q;
  assign rsp_rdata_o      = rdata_q;
  assign job_id_o         = next_id;
  assign job_src_o        = desc.src;
  assign job_dst_o        = desc.dst;
  assign job_len_o        = desc.len;
  assign job_src_stride_o = desc.sstr;
  assign job_dst_stride_o = desc.dstr;
  assign job_reps_o       = desc.reps;
  assign job_decouple_o   = desc.cfg[0];
  assign job_deburst_o    = desc.cfg[1];
  assign job_serialize_o  = desc.cfg[2];
  assign job_two_d_o      = (desc.reps != '0);

endmodule

// File: rtl/dma_job_regs_chk.sv
module dma_job_regs_chk #(
  parameter int AddrWidth = 7,
  parameter int IdWidth   = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [AddrWidth-1:0] addr_i,
  input logic                 rsp_valid_o,
  input logic [63:0]          rsp_rdata_o,
  input logic                 job_valid_o,
  input logic                 job_ready_i,
  input logic [IdWidth-1:0]   job_id_o,
  input logic [63:0]          job_len_o
);

  logic is_launch;
  assign is_launch = req_i && !we_i && (int'(addr_i[AddrWidth-1:3]) == 5);

  a_r9_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);

  a_r9_no_rsp_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);

  a_r5_offer_needs_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_valid_o |-> (job_len_o != '0));

  a_r4_ticket_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_valid_o |-> (job_id_o != '0));

  a_r3_launch_returns_ticket: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (job_valid_o && job_ready_i) |=>
      (rsp_rdata_o == {{(64-IdWidth){1'b0}}, $past(job_id_o)}));

  a_r5_refused_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_launch && !(job_valid_o && job_ready_i)) |=> (rsp_rdata_o == '0));

  a_r4_ticket_holds_unless_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(job_valid_o && job_ready_i) |=> $stable(job_id_o));

endmodule

bind dma_job_regs dma_job_regs_chk #(.AddrWidth(AddrWidth), .IdWidth(IdWidth)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_rdata_o (rsp_rdata_o),
  .job_valid_o (job_valid_o),
  .job_ready_i (job_ready_i),
  .job_id_o    (job_id_o),
  .job_len_o   (job_len_o)
);

// File: tb/sim_dma_job_regs.sv
`timescale 1ns/1ps
module sim_dma_job_regs;

  localparam int AW = 7;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0, job_ready = 1'b0, done = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [63:0]   wdata = '0;
  logic          rsp_valid, job_valid, dec, deb, ser, two_d;
  logic [63:0]   rsp_rdata, jsrc, jdst, jlen, jss, jds, jreps;
  logic [IW-1:0] jid;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  dma_job_regs #(.AddrWidth(AW), .IdWidth(IW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .job_valid_o(job_valid),
    .job_ready_i(job_ready), .job_id_o(jid), .job_src_o(jsrc), .job_dst_o(jdst),
    .job_len_o(jlen), .job_src_stride_o(jss), .job_dst_stride_o(jds), .job_reps_o(jreps),
    .job_decouple_o(dec), .job_deburst_o(deb), .job_serialize_o(ser),
    .job_two_d_o(two_d), .done_i(done)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one request; jv = job_valid seen during it, rd = response data
  logic jv_seen;
  task automatic access(input logic w, input logic [AW-1:0] a, input logic [63:0] d,
                        output logic [63:0] rd);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1 jv_seen = job_valid;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    check("R9 rsp_valid", {63'd0, rsp_valid}, 64'd1);
    rd = rsp_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  typedef struct packed {
    logic          w;
    logic [AW-1:0] a;
    logic [63:0]   d;
    logic [63:0]   e;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 7'h00, 64'hA5A5_0000_1234_5678, 64'd0},                  // R1 write src
    '{1'b0, 7'h00, 64'd0, 64'hA5A5_0000_1234_5678},                  // R1 read src
    '{1'b1, 7'h08, 64'h0000_00BE_EF00_0040, 64'd0},                  // R1 write dst
    '{1'b0, 7'h08, 64'd0, 64'h0000_00BE_EF00_0040},                  // R1 read dst
    '{1'b1, 7'h18, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0},                  // R2 write options
    '{1'b0, 7'h18, 64'd0, 64'd7},                                    // R2 only 3 bits kept
    '{1'b1, 7'h20, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0},                  // R8 status write
    '{1'b0, 7'h20, 64'd0, 64'd0},                                    // R8 R7 still idle
    '{1'b1, 7'h30, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0},                  // R8 done write
    '{1'b0, 7'h30, 64'd0, 64'd0},                                    // R8 R6 still 0
    '{1'b0, 7'h58, 64'd0, 64'd0},                                    // R8 unmapped
    '{1'b1, 7'h38, 64'h0000_0000_0000_0100, 64'd0},                  // R1 src stride
    '{1'b0, 7'h38, 64'd0, 64'h0000_0000_0000_0100},                  // R1
    '{1'b1, 7'h40, 64'h8000_0000_0000_0200, 64'd0},                  // R1 dst stride
    '{1'b0, 7'h40, 64'd0, 64'h8000_0000_0000_0200},                  // R1
    '{1'b1, 7'h48, 64'd3, 64'd0},                                    // R1 repeats
    '{1'b0, 7'h48, 64'd0, 64'd3}                                     // R1
  };

  logic [63:0] rd;

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check("R3 reset job_valid", {63'd0, job_valid}, 64'd0);
    rst_n = 1'b1;
    access(1'b0, 7'h20, 64'd0, rd); check("R7 reset busy", rd, 64'd0);
    access(1'b0, 7'h30, 64'd0, rd); check("R6 reset done", rd, 64'd0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].w, VEC[i].a, VEC[i].d, rd);
      check($sformatf("R1/R2/R8/R9 vector %0d", i), rd, VEC[i].e);
    end

    // R5: zero byte count refuses
    job_ready = 1'b1;
    access(1'b0, 7'h28, 64'd0, rd);
    check("R5 zero length id", rd, 64'd0);
    check("R5 zero length valid", {63'd0, jv_seen}, 64'd0);

    access(1'b1, 7'h10, 64'h100, rd);
    // R5: engine not ready
    job_ready = 1'b0;
    access(1'b0, 7'h28, 64'd0, rd);
    check("R5 not ready id", rd, 64'd0);
    access(1'b0, 7'h20, 64'd0, rd); check("R5 not ready no busy", rd, 64'd0);

    // R3 R4 R10: first accepted job
    job_ready = 1'b1;
    access(1'b0, 7'h28, 64'd0, rd);
    check("R4 first ticket", rd, 64'd1);
    check("R3 valid seen", {63'd0, jv_seen}, 64'd1);
    check("R3 src field", jsrc, 64'hA5A5_0000_1234_5678);
    check("R3 dst field", jdst, 64'h0000_00BE_EF00_0040);
    check("R3 len field", jlen, 64'h100);
    check("R3 strides", jss ^ jds, 64'h8000_0000_0000_0300);
    check("R2 flags", {61'd0, ser, deb, dec}, 64'd7);
    check("R10 two-d", {63'd0, two_d}, 64'd1);
    access(1'b0, 7'h20, 64'd0, rd); check("R7 busy", rd, 64'd1);
    access(1'b0, 7'h30, 64'd0, rd); check("R6 none done", rd, 64'd0);

    access(1'b0, 7'h28, 64'd0, rd); check("R4 second ticket", rd, 64'd2);
    access(1'b1, 7'h48, 64'd0, rd);
    check("R10 one-d", {63'd0, two_d}, 64'd0);
    access(1'b0, 7'h28, 64'd0, rd); check("R4 third ticket", rd, 64'd3);

    pulse_done();
    access(1'b0, 7'h30, 64'd0, rd); check("R6 done 1", rd, 64'd1);
    access(1'b0, 7'h20, 64'd0, rd); check("R7 still busy", rd, 64'd1);
    pulse_done(); pulse_done();
    access(1'b0, 7'h30, 64'd0, rd); check("R6 done 3", rd, 64'd3);
    access(1'b0, 7'h20, 64'd0, rd); check("R7 idle", rd, 64'd0);
    pulse_done();
    access(1'b0, 7'h30, 64'd0, rd); check("R6 stray pulse ignored", rd, 64'd3);

    // R4 wrap and R5 full
    for (int k = 0; k < 15; k++) begin
      access(1'b0, 7'h28, 64'd0, rd);
      check("R4 ticket sequence", rd, 64'((k + 3) % 15 + 1));
    end
    access(1'b0, 7'h28, 64'd0, rd);
    check("R5 full id", rd, 64'd0);
    check("R5 full valid", {63'd0, jv_seen}, 64'd0);
    pulse_done();
    access(1'b0, 7'h30, 64'd0, rd); check("R6 oldest after wrap", rd, 64'd4);
    for (int k = 0; k < 14; k++) pulse_done();
    access(1'b0, 7'h30, 64'd0, rd); check("R6 drained", rd, 64'd3);
    access(1'b0, 7'h20, 64'd0, rd); check("R7 drained idle", rd, 64'd0);

    // R8 write to launch ignored, R9 write response is zero
    access(1'b1, 7'h28, 64'hFFFF, rd);
    check("R9 write response", rd, 64'd0);
    check("R8 write launches nothing", {63'd0, jv_seen}, 64'd0);
    access(1'b0, 7'h20, 64'd0, rd); check("R8 no busy after write", rd, 64'd0);
    access(1'b0, 7'h28, 64'd0, rd); check("R8 ticket unchanged", rd, 64'd4);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule